// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host reach an external asynchronous static RAM of 512K locations by 8 bits. The host raises a one-cycle request with a write/read flag, an address and, for writes, a data byte. The controller then drives the memory's active-low chip select, output enable and write enable, the address bus, and a split data bus made of data-out, driver enable and data-in. While an access runs, `host_ready` is low. A read ends with a one-cycle `host_rvalid` strobe carrying the byte.

Every strobe interval is a whole number of clock cycles. Each count is derived at build time from nanosecond limits and the clock period, so the same RTL serves any clock rate. Reads hold chip select and output enable low together for the access count. Writes set up the address and data one cycle before write enable falls, hold write enable low for the pulse count, and keep address and data one cycle after write enable rises. The controller never turns its data drivers on until the memory's output has had time to go high-impedance after a read.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and for as long as reset stays high, chip select, output enable and write enable are high, the data drivers are off, `host_ready` is high and `host_rvalid` is low. Reset is synchronous and active high.
- R2: Each timing count is the nanosecond limit divided by `CLK_PERIOD_NS`, rounded up, and never less than one. With a 4 ns clock the defaults give these counts: access 18, write pulse 15, write cycle 18, release-to-high-Z 7.
- R3: A read pulls chip select and output enable low on the same edge that presents the address, with write enable high. All three stay in that state for exactly the access count of cycles. The access count covers the address access time, the read cycle time and output-enable access. `host_ready` is low for exactly those cycles.
- R4: The read byte is sampled from `mem_dq_in` in the last cycle of the access window. It appears on `host_rdata` with a one-cycle `host_rvalid` pulse, on the same edge that raises chip select and output enable. The pulse is seen the access count plus one cycles after the request cycle.
- R5: A write drives the address and data, enables the data drivers and pulls chip select low one cycle before write enable falls. Output enable stays high for the whole write, because a write does not depend on output enable.
- R6: Write enable stays low for exactly the write-pulse count. That count covers the write pulse width, address-valid-to-end, select-to-end and data-setup limits. Address and data stay stable while chip select is low. One further cycle with chip select low and data driven follows the rising edge of write enable.
- R7: A write that needs no bus turnaround keeps `host_ready` low for the larger of two values: the write-cycle count, or the write-pulse count plus two.
- R8: After output enable rises, the data drivers stay off for at least the release-to-high-Z count. A write that follows a read waits for this interval.
- R9: A request made while `host_ready` is low is ignored. It causes no memory write and leaves the stored data unchanged.
- R10: The data drivers are never on while output enable is low, and write enable is only low while chip select is low.
- R11: Host address bit i drives memory address bit i. Data bytes pass unchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, accepted only when host_ready is high |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Access address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | High when a new request can be accepted |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | One-cycle read completion strobe |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 19 | Memory address bus |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the controller's data drivers |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Some rules are checked by assertions on every cycle. They cover the safety rules between strobes (no drivers while output enable is low, write enable only under chip select, output enable high during writes), address and data stability under chip select, the exact write-pulse width, the turnaround gap before the drivers turn on, the single-cycle read strobe, and the idle state during reset. Other behaviour only the bench scenarios can show, because it needs a memory model. That covers whether the byte captured at the end of the access window is the stored one rather than early garbage, whether a write lands at the right full address, total busy lengths, and that a request made while busy leaves the memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_WR_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_REC
  } seq_state_e;

  // ceiling conversion of a ns limit into clock cycles, minimum one
  function automatic int ns_to_cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_turn_guard.sv
module sram_turn_guard #(
  parameter int CNT_W  = 5,
  parameter int HZ_CYC = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic clear
);
  logic [CNT_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)                gap_q <= '0;
    else if (start)         gap_q <= CNT_W'(HZ_CYC);
    else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
  end

  // drivers may turn on at the edge that completes the high-Z interval
  assign clear = (gap_q <= CNT_W'(1));
endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 5,
  parameter int ACC_CYC = 18,
  parameter int WP_CYC  = 15,
  parameter int PAD_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  input  logic              tmr_last,
  input  logic              turn_clear,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              turn_start
);
  localparam bit HAS_PAD = (PAD_CYC > 0);

  seq_state_e state_q;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (host_req && !host_wr) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(ACC_CYC);
      end
      ST_WR_SETUP: begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC);
      end
      ST_WR_HOLD: if (HAS_PAD) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PAD_CYC);
      end
      default: ;
    endcase
  end

  assign turn_start = (state_q == ST_RD_ACC) && tmr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      host_ready  <= 1'b1;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
      mem_cs_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_addr    <= '0;
      mem_dq_out  <= '0;
      mem_dq_oe   <= 1'b0;
    end else begin
      host_rvalid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (host_req) begin
          mem_addr   <= host_addr;
          host_ready <= 1'b0;
          if (!host_wr) begin
            mem_cs_n <= 1'b0;
            mem_oe_n <= 1'b0;
            state_q  <= ST_RD_ACC;
          end else begin
            mem_dq_out <= host_wdata;
            if (turn_clear) begin
              mem_cs_n  <= 1'b0;
              mem_dq_oe <= 1'b1;
              state_q   <= ST_WR_SETUP;
            end else begin
              state_q <= ST_WR_TURN;
            end
          end
        end
        ST_RD_ACC: if (tmr_last) begin
          host_rdata  <= mem_dq_in;
          host_rvalid <= 1'b1;
          host_ready  <= 1'b1;
          mem_cs_n    <= 1'b1;
          mem_oe_n    <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_WR_TURN: if (turn_clear) begin
          mem_cs_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          state_q   <= ST_WR_SETUP;
        end
        ST_WR_SETUP: begin
          mem_we_n <= 1'b0;
          state_q  <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (tmr_last) begin
          mem_we_n <= 1'b1;
          state_q  <= ST_WR_HOLD;
        end
        ST_WR_HOLD: begin
          mem_cs_n  <= 1'b1;
          mem_dq_oe <= 1'b0;
          if (HAS_PAD) begin
            state_q <= ST_WR_REC;
          end else begin
            host_ready <= 1'b1;
            state_q    <= ST_IDLE;
          end
        end
        ST_WR_REC: if (tmr_last) begin
          host_ready <= 1'b1;
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 4,
  parameter int T_AA_NS       = 70,
  parameter int T_RC_NS       = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_HZ_NS       = 25,
  parameter int T_WC_NS       = 70,
  parameter int T_WP_NS       = 55,
  parameter int T_AW_NS       = 60,
  parameter int T_CW_NS       = 60,
  parameter int T_DW_NS       = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_ready,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int ACC_CYC = ns_to_cyc(max2(max2(T_AA_NS, T_RC_NS), T_OE_NS), CLK_PERIOD_NS);
  localparam int WP_CYC  = ns_to_cyc(max2(max2(T_WP_NS, T_AW_NS), max2(T_CW_NS, T_DW_NS)),
                                     CLK_PERIOD_NS);
  localparam int WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int PAD_CYC = (WC_CYC > WP_CYC + 2) ? (WC_CYC - WP_CYC - 2) : 0;
  localparam int MAX_CYC = max2(max2(ACC_CYC, WP_CYC), max2(HZ_CYC, PAD_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             turn_start;
  logic             turn_clear;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  sram_turn_guard #(.CNT_W(CNT_W), .HZ_CYC(HZ_CYC)) u_guard (
    .clk   (clk),
    .rst   (rst),
    .start (turn_start),
    .clear (turn_clear)
  );

  sram_access_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .ACC_CYC (ACC_CYC),
    .WP_CYC  (WP_CYC),
    .PAD_CYC (PAD_CYC)
  ) u_seq (
    .clk         (clk),
    .rst         (rst),
    .host_req    (host_req),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_ready  (host_ready),
    .host_rdata  (host_rdata),
    .host_rvalid (host_rvalid),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_addr    (mem_addr),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_oe   (mem_dq_oe),
    .mem_dq_in   (mem_dq_in),
    .tmr_last    (tmr_last),
    .turn_clear  (turn_clear),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .turn_start  (turn_start)
  );
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8,
  parameter int WP_CYC = 15,
  parameter int HZ_CYC = 7
) (
  input logic              clk,
  input logic              rst,
  input logic              host_ready,
  input logic              host_rvalid,
  input logic              mem_cs_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic [15:0] we_run_q;
  logic [15:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)            we_run_q <= '0;
    else if (!mem_we_n) we_run_q <= we_run_q + 1'b1;
    else                we_run_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst)                         gap_q <= 16'(HZ_CYC);
    else if (!mem_oe_n)              gap_q <= '0;
    else if (gap_q < 16'(HZ_CYC))    gap_q <= gap_q + 1'b1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && host_ready && !host_rvalid));

  assert_read_strobes_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> ($fell(mem_cs_n) && mem_we_n));

  assert_rvalid_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |=> !host_rvalid);

  assert_rvalid_release_R4: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> (mem_cs_n && mem_oe_n));

  assert_oe_high_in_write_R5: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_oe_n);

  assert_we_width_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run_q == 16'(WP_CYC)));

  assert_hold_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_dq_oe));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

  assert_turnaround_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> (gap_q >= 16'(HZ_CYC)));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> !host_ready);

  assert_no_contention_R10: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  assert_we_under_cs_R10: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_cs_n);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .WP_CYC (WP_CYC),
  .HZ_CYC (HZ_CYC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .host_ready  (host_ready),
  .host_rvalid (host_rvalid),
  .mem_cs_n    (mem_cs_n),
  .mem_oe_n    (mem_oe_n),
  .mem_we_n    (mem_we_n),
  .mem_addr    (mem_addr),
  .mem_dq_out  (mem_dq_out),
  .mem_dq_oe   (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
`timescale 1ns/1ps
module test_sram_async_ctrl;
  localparam int P     = 4;
  localparam int ACC_X = (70 + P - 1) / P;   // R2: 18
  localparam int WP_X  = (60 + P - 1) / P;   // R2: 15
  localparam int WC_X  = (70 + P - 1) / P;   // R2: 18
  localparam int HZ_X  = (25 + P - 1) / P;   // R2: 7
  localparam int WBUSY_X = (WC_X > WP_X + 2) ? WC_X : WP_X + 2;

  // {wr, addr, data}: writes first, then reads expecting the same data
  localparam logic [27:0] VEC [8] = '{
    {1'b1, 19'h00000, 8'h5A},
    {1'b1, 19'h7FFFF, 8'hC3},
    {1'b1, 19'h2AAAA, 8'h00},
    {1'b1, 19'h55555, 8'hFF},
    {1'b0, 19'h55555, 8'hFF},
    {1'b0, 19'h00000, 8'h5A},
    {1'b0, 19'h7FFFF, 8'hC3},
    {1'b0, 19'h2AAAA, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [18:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [18:0] mem_addr;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in = 8'hEE;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sram_async_ctrl i_sram_async_ctrl (
    .clk (clk), .rst (rst),
    .host_req (host_req), .host_wr (host_wr), .host_addr (host_addr),
    .host_wdata (host_wdata), .host_ready (host_ready),
    .host_rdata (host_rdata), .host_rvalid (host_rvalid),
    .mem_cs_n (mem_cs_n), .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n),
    .mem_addr (mem_addr), .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe),
    .mem_dq_in (mem_dq_in)
  );

  // ---------------- memory model, sampled on falling edges ----------------
  logic [7:0] mem_m [int];
  int  wp_run = 0, last_wp = 0, wr_count = 0, rd_run = 0, gap = 100, drv_gap = -1;
  bit  prev_setup = 0, setup_ok = 0, oe_in_write = 0, prev_drv = 0;
  logic [18:0] wa;
  logic [7:0]  wd;

  always @(negedge clk) begin
    if (!mem_cs_n && !mem_we_n) begin
      if (wp_run == 0) setup_ok = prev_setup;
      if (!mem_oe_n) oe_in_write = 1;
      wp_run++;
      wa = mem_addr;
      wd = mem_dq_out;
    end else if (wp_run != 0) begin
      mem_m[int'(wa)] = wd;
      last_wp = wp_run;
      wr_count++;
      wp_run = 0;
    end
    prev_setup = !mem_cs_n && mem_we_n && mem_dq_oe && mem_oe_n;
    if (!mem_cs_n && !mem_oe_n && mem_we_n) rd_run++;
    else rd_run = 0;
    if (rd_run >= ACC_X)
      mem_dq_in <= mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
    else
      mem_dq_in <= 8'hEE;
    if (!mem_oe_n) gap = 0;
    else if (gap < 100) gap++;
    if (mem_dq_oe && !prev_drv) drv_gap = gap;
    prev_drv = mem_dq_oe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input bit wr, input logic [18:0] a, input logic [7:0] d,
                        output int busy, output int lat, output logic [7:0] rd);
    int n;
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
    busy = 0; lat = -1; rd = 8'h00; n = 0;
    @(negedge clk);
    host_req = 1'b0;
    forever begin
      n++;
      if (host_rvalid) begin lat = n; rd = host_rdata; end
      if (host_ready) break;
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic check_idle(input string tag);
    chk(mem_cs_n && mem_oe_n && mem_we_n, tag, "strobes high",
        {mem_cs_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe, tag, "drivers off", mem_dq_oe, 0);
    chk(host_ready && !host_rvalid, tag, "ready/rvalid", {host_ready, host_rvalid}, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int busy, lat, wc0;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");

    // table walk: writes then reads
    foreach (VEC[i]) begin
      run_op(VEC[i][27], VEC[i][26:8], VEC[i][7:0], busy, lat, rd);
      if (VEC[i][27]) begin
        chk(mem_m.exists(int'(VEC[i][26:8])) && mem_m[int'(VEC[i][26:8])] == VEC[i][7:0],
            "R11", "stored byte", mem_m.exists(int'(VEC[i][26:8])) ? mem_m[int'(VEC[i][26:8])] : -1,
            VEC[i][7:0]);
        chk(last_wp == WP_X, "R6", "write pulse cycles", last_wp, WP_X);
        chk(busy == WBUSY_X, "R7", "write busy cycles", busy, WBUSY_X);
        chk(setup_ok, "R5", "setup cycle before pulse", setup_ok, 1);
        chk(!oe_in_write, "R5", "oe high during write", oe_in_write, 0);
      end else begin
        chk(rd == VEC[i][7:0], "R4", "read byte", rd, VEC[i][7:0]);
        chk(lat == ACC_X + 1, "R4", "rvalid latency", lat, ACC_X + 1);
        chk(busy == ACC_X, "R3", "read busy cycles (R2 count)", busy, ACC_X);
      end
    end

    // request while busy is ignored
    wc0 = wr_count;
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 19'h2AAAA;
    @(negedge clk);
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 19'h2AAAA; host_wdata = 8'h77;
    @(negedge clk);
    host_req = 1'b0;
    while (!host_ready) @(negedge clk);
    chk(host_rdata == 8'h00, "R9", "read during ignored req", host_rdata, 0);
    repeat (30) @(negedge clk);
    chk(wr_count == wc0, "R9", "no memory write", wr_count, wc0);
    chk(host_ready, "R9", "still idle", host_ready, 1);
    run_op(1'b0, 19'h2AAAA, 8'h00, busy, lat, rd);
    chk(rd == 8'h00, "R9", "data unchanged", rd, 0);

    // read followed at once by write: turnaround
    drv_gap = -1;
    run_op(1'b1, 19'h01234, 8'hA5, busy, lat, rd);
    chk(drv_gap > HZ_X, "R8", "driver gap after read", drv_gap, HZ_X + 1);
    chk(busy > WBUSY_X, "R8", "write delayed by turnaround", busy, WBUSY_X + 1);
    run_op(1'b0, 19'h01234, 8'h00, busy, lat, rd);
    chk(rd == 8'hA5, "R11", "turnaround write readback", rd, 8'hA5);

    // reset in the middle of a read
    @(negedge clk);
    host_req = 1'b1; host_wr = 1'b0; host_addr = 19'h7FFFF;
    @(negedge clk);
    host_req = 1'b0;
    repeat (4) @(negedge clk);
    chk(!mem_cs_n && !mem_oe_n, "R3", "strobes low mid-read", {mem_cs_n, mem_oe_n}, 0);
    rst = 1'b1;
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_idle("R1");
    run_op(1'b0, 19'h7FFFF, 8'h00, busy, lat, rd);
    chk(rd == 8'hC3, "R4", "read after mid reset", rd, 8'hC3);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule